// File: doc/BRIEF.md
# Time Base and Decrementer Counter Unit

This block keeps a 64-bit time base that counts up and a 32-bit decrementer that counts down. Both move once for each cycle in which the tick-enable input is high. That input comes from a divided time-base clock outside the block. Software reaches the three registers through a single-cycle write port and a combinational read port. The time base is split into a lower word and an upper word. The decrementer has a register of its own.

The decrementer raises a sticky interrupt request in two cases: when it counts through zero, and when software writes a negative value over a non-negative one. The request stays high until the acknowledge input clears it. A separate reload input loads the decrementer with all ones and raises no request. Use it at initialisation or when the tick frequency changes.

A legacy clock mode presents a coarse view of the lower time-base word. Reads and writes of that word pass through the mask 0x3FFFFF80, which suits a nominal 7.8125 MHz tick. The upper word and the decrementer are not affected by this mode.

Top module: `timebase_decr`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge), the time base reads 0, the decrementer reads 0xFFFFFFFF and dec_irq is 0.
- R2: In a cycle with tick_en high and no write to either time-base word, the 64-bit time base increases by one, and the carry passes from the lower word into the upper word. With tick_en low it holds its value.
- R3: A write to the upper word (wr_sel 1) replaces bits 63:32 and keeps the current lower word. A write to the lower word (wr_sel 0) replaces bits 31:0 and keeps the current upper word.
- R4: In a cycle with tick_en high, no decrementer write and no reload, the decrementer decreases by one.
- R5: A tick that finds the decrementer at 0x00000000 moves it to 0xFFFFFFFF and sets dec_irq from the next cycle on.
- R6: A decrementer write (wr_sel 2) sets dec_irq when bit 31 of the written value is 1 and bit 31 of the current value is 0. Any other decrementer write leaves dec_irq unchanged.
- R7: reload_evt loads the decrementer with 0xFFFFFFFF and never sets dec_irq. It takes priority over a decrementer write and over a tick in the same cycle.
- R8: dec_irq stays high until a cycle with irq_ack high clears it. A set condition in the same cycle as irq_ack wins, and dec_irq stays 1.
- R9: When a software write and a tick arrive in the same cycle, the written register takes the written value with no tick applied. A register that is not written still ticks.
- R10: With legacy_mode high, a read of the lower word returns it ANDed with 0x3FFFFF80, and a write of the lower word stores the written value ANDed with 0x3FFFFF80. The upper word and the decrementer behave as in normal mode.
- R11: Register select encoding for rd_sel and wr_sel: 0 is the lower time-base word, 1 is the upper word, 2 is the decrementer. Selection 3 reads as 0, and a write to it changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Time-base tick enable, one step per high cycle |
| reload_evt | input | 1 | Initialisation or frequency-change event; loads the decrementer with all ones |
| legacy_mode | input | 1 | Selects the masked view of the lower time-base word |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register selected for the write |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Register selected for the read |
| rd_data | output | 32 | Combinational read data |
| irq_ack | input | 1 | Clears the interrupt request |
| dec_irq | output | 1 | Sticky decrementer interrupt request |

## Verification
Random cycles mix ticks, writes to all four selections, acknowledges, reloads and legacy-mode toggles. Decrementer writes are often small, so the counter reaches zero many times. These cycles separate a correct count from an off-by-one, a wrong write-versus-tick priority or a lost sticky request. Directed cases target the corners. A lower word of all ones shows the carry into the upper word. A negative value written over a non-negative one raises the request, while a negative value over a negative one does not. Reload in the same cycle as a negative write must stay silent. Acknowledge in the same cycle as a set must leave the request high. A write to selection 3 must change nothing.

// File: rtl/tbd_pkg.sv
// Shared definitions for the time base and decrementer unit.
package tbd_pkg;
    parameter int WORD_W = 32;

    // Register selection code used on both the read and the write port.
    typedef enum logic [1:0] {
        SEL_TB_LO = 2'd0,
        SEL_TB_HI = 2'd1,
        SEL_DEC   = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    // Lower-word view used in the legacy clock mode.
    localparam logic [WORD_W-1:0] LEGACY_MASK = 32'h3FFF_FF80;
endpackage

// File: rtl/tbd_timebase.sv
// Up-counting time base of two words.
// Advances by one on tick. A write of either half replaces only that half and
// suppresses the tick for the cycle. Assumes at most one write strobe per cycle.
module tbd_timebase #(
    parameter int WORD_W = 32,
    parameter logic [WORD_W-1:0] LO_MASK = '1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic                legacy,
    input  logic [WORD_W-1:0]   wr_data,
    output logic [2*WORD_W-1:0] tb_q
);
    localparam int TB_W = 2 * WORD_W;
    localparam logic [TB_W-1:0] TB_ONE = {{(TB_W-1){1'b0}}, 1'b1};

    logic [TB_W-1:0]   tb_next;
    logic [WORD_W-1:0] lo_wr_val;

    // Apply the legacy mask to data written into the lower word.
    always_comb begin
        lo_wr_val = legacy ? (wr_data & LO_MASK) : wr_data;
    end

    // Next value: a write replaces one half, otherwise the tick steps the count.
    always_comb begin
        tb_next = tb_q;
        if (wr_lo) begin
            tb_next = {tb_q[TB_W-1:WORD_W], lo_wr_val};
        end else if (wr_hi) begin
            tb_next = {wr_data, tb_q[WORD_W-1:0]};
        end else if (tick) begin
            tb_next = tb_q + TB_ONE;
        end
    end

    // Time base register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tb_q <= '0;
        end else begin
            tb_q <= tb_next;
        end
    end

    p_tick_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_lo && !wr_hi) |=> (tb_q == $past(tb_q) + TB_ONE));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_lo && !wr_hi) |=> $stable(tb_q));

    p_hi_keeps_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !wr_lo) |=> (tb_q[WORD_W-1:0] == $past(tb_q[WORD_W-1:0])));

    p_lo_keeps_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !wr_hi) |=> (tb_q[TB_W-1:WORD_W] == $past(tb_q[TB_W-1:WORD_W])));

    p_legacy_store_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && legacy) |=> ((tb_q[WORD_W-1:0] & ~LO_MASK) == '0));
endmodule

// File: rtl/tbd_decrementer.sv
// Down-counting decrementer.
// Reload wins over a write, and a write wins over a tick. It reports an expiry
// (a tick taken at zero) and a negative load (sign bit set over a clear one).
module tbd_decrementer #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr,
    input  logic              reload,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] dec_q,
    output logic              expire,
    output logic              neg_load
);
    localparam int MSB = WORD_W - 1;
    localparam logic [WORD_W-1:0] ALL_ONES = '1;
    localparam logic [WORD_W-1:0] DEC_ONE  = {{(WORD_W-1){1'b0}}, 1'b1};

    logic [WORD_W-1:0] dec_next;

    // Event detection, each qualified by the priority of the operations.
    always_comb begin
        expire   = tick && !wr && !reload && (dec_q == '0);
        neg_load = wr && !reload && wr_data[MSB] && !dec_q[MSB];
    end

    // Next value by priority; stepping down from zero wraps to all ones.
    always_comb begin
        dec_next = dec_q;
        if (reload) begin
            dec_next = ALL_ONES;
        end else if (wr) begin
            dec_next = wr_data;
        end else if (tick) begin
            dec_next = dec_q - DEC_ONE;
        end
    end

    // Decrementer register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q <= ALL_ONES;
        end else begin
            dec_q <= dec_next;
        end
    end

    p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr && !reload) |=> (dec_q == $past(dec_q) - DEC_ONE));

    p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (dec_q == ALL_ONES));

    p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (dec_q == ALL_ONES));

    p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !reload) |=> (dec_q == $past(wr_data)));
endmodule

// File: rtl/tbd_irq_latch.sv
// Sticky interrupt request: set wins over acknowledge in the same cycle.
module tbd_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic ack,
    output logic irq
);
    // Request flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= set || (irq && !ack);
        end
    end

    p_set_raises_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> irq);

    p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !set) |=> !irq);

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack) |=> irq);
endmodule

// File: rtl/timebase_decr.sv
// Top of the time base and decrementer unit.
// Decodes the write port, joins the two interrupt causes into one sticky
// request and muxes the read port. Reads are combinational from the registers.
module timebase_decr (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_en,
    input  logic        reload_evt,
    input  logic        legacy_mode,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [31:0] wr_data,
    input  logic [1:0]  rd_sel,
    output logic [31:0] rd_data,
    input  logic        irq_ack,
    output logic        dec_irq
);
    import tbd_pkg::*;

    localparam int TB_W = 2 * WORD_W;

    reg_sel_e          wsel, rsel;
    logic              wr_lo, wr_hi, wr_dec;
    logic [TB_W-1:0]   tb_q;
    logic [WORD_W-1:0] dec_q;
    logic              expire, neg_load;

    // Write decode; selection 3 strobes nothing.
    always_comb begin
        wsel   = reg_sel_e'(wr_sel);
        wr_lo  = wr_en && (wsel == SEL_TB_LO);
        wr_hi  = wr_en && (wsel == SEL_TB_HI);
        wr_dec = wr_en && (wsel == SEL_DEC);
    end

    tbd_timebase #(.WORD_W(WORD_W), .LO_MASK(LEGACY_MASK)) u_tb (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_en),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .legacy  (legacy_mode),
        .wr_data (wr_data),
        .tb_q    (tb_q)
    );

    tbd_decrementer #(.WORD_W(WORD_W)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_en),
        .wr       (wr_dec),
        .reload   (reload_evt),
        .wr_data  (wr_data),
        .dec_q    (dec_q),
        .expire   (expire),
        .neg_load (neg_load)
    );

    tbd_irq_latch u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (expire || neg_load),
        .ack   (irq_ack),
        .irq   (dec_irq)
    );

    // Read mux with the legacy view of the lower word.
    always_comb begin
        rsel = reg_sel_e'(rd_sel);
        unique case (rsel)
            SEL_TB_LO: rd_data = legacy_mode ? (tb_q[WORD_W-1:0] & LEGACY_MASK)
                                             : tb_q[WORD_W-1:0];
            SEL_TB_HI: rd_data = tb_q[TB_W-1:WORD_W];
            SEL_DEC:   rd_data = dec_q;
            default:   rd_data = '0;
        endcase
    end

    p_reload_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_evt && !dec_irq) |=> !dec_irq);

    p_null_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wsel == SEL_NONE && !tick_en && !reload_evt)
            |=> ($stable(tb_q) && $stable(dec_q)));
endmodule

// File: tb/sim_timebase_decr.sv
module sim_timebase_decr;
    localparam logic [31:0] MASK = 32'h3FFF_FF80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0, reload_evt = 1'b0, legacy_mode = 1'b0;
    logic        wr_en = 1'b0, irq_ack = 1'b0;
    logic [1:0]  wr_sel = 2'd0, rd_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        dec_irq;

    logic [63:0] m_tb;
    logic [31:0] m_dec;
    logic        m_irq;
    int checks = 0, fails = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    timebase_decr u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reload_evt(reload_evt),
        .legacy_mode(legacy_mode), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .irq_ack(irq_ack), .dec_irq(dec_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input int s);
        case (s)
            0: return legacy_mode ? (m_tb[31:0] & MASK) : m_tb[31:0];
            1: return m_tb[63:32];
            2: return m_dec;
            default: return 32'h0;
        endcase
    endfunction

    // Reference update from the requirements, using pre-edge state.
    task automatic model_step();
        logic set;
        set = 1'b0;
        if (wr_en && wr_sel == 2'd0)
            m_tb = {m_tb[63:32], legacy_mode ? (wr_data & MASK) : wr_data}; // R3 R10 R9
        else if (wr_en && wr_sel == 2'd1)
            m_tb = {wr_data, m_tb[31:0]};                                  // R3 R9
        else if (tick_en)
            m_tb = m_tb + 64'd1;                                           // R2
        if (reload_evt)
            m_dec = 32'hFFFF_FFFF;                                         // R7
        else if (wr_en && wr_sel == 2'd2) begin
            if (wr_data[31] && !m_dec[31]) set = 1'b1;                     // R6
            m_dec = wr_data;
        end else if (tick_en) begin
            if (m_dec == 32'h0) set = 1'b1;                                // R5
            m_dec = m_dec - 32'd1;                                         // R4
        end
        m_irq = set | (m_irq & ~irq_ack);                                  // R8
    endtask

    // Compare all four read selections and the request; called at a falling edge.
    task automatic verify(input string req);
        for (int s = 0; s < 4; s++) begin
            rd_sel = 2'(s);
            #1;
            chk(req, rd_data, exp_read(s));
        end
        chk(req, {31'd0, dec_irq}, {31'd0, m_irq});
    endtask

    // One cycle: drive at the falling edge, update the model at the rising edge.
    task automatic cyc(input string req, input logic t, input logic w, input logic [1:0] ws,
                       input logic [31:0] d, input logic rl, input logic ak);
        tick_en = t; wr_en = w; wr_sel = ws; wr_data = d; reload_evt = rl; irq_ack = ak;
        @(posedge clk);
        model_step();
        @(negedge clk);
        tick_en = 0; wr_en = 0; reload_evt = 0; irq_ack = 0;
        verify(req);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED);
        m_tb = '0; m_dec = 32'hFFFF_FFFF; m_irq = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        verify("R1");                                                  // reset state

        cyc("R2", 1, 0, 0, 0, 0, 0);                                   // single tick
        cyc("R2", 0, 0, 0, 0, 0, 0);                                   // hold
        cyc("R3", 0, 1, 0, 32'hFFFF_FFFF, 0, 0);                       // lower = all ones
        cyc("R3", 0, 1, 1, 32'h0000_0012, 0, 0);                       // upper write keeps lower
        cyc("R2", 1, 0, 0, 0, 0, 0);                                   // carry into upper
        chk("R2", rd_data, 32'h0);                                     // rd_sel 3 last -> 0
        cyc("R9", 1, 1, 0, 32'h0000_1000, 0, 0);                       // write beats tick on lower
        cyc("R9", 1, 1, 2, 32'h0000_0002, 0, 0);                       // dec write beats tick, tb ticks
        cyc("R4", 1, 0, 0, 0, 0, 0);
        cyc("R4", 1, 0, 0, 0, 0, 0);                                   // now zero
        cyc("R5", 1, 0, 0, 0, 0, 0);                                   // expiry
        chk("R5", {31'd0, dec_irq}, 32'd1);
        cyc("R8", 0, 0, 0, 0, 0, 0);                                   // sticky
        cyc("R8", 0, 0, 0, 0, 0, 1);                                   // ack clears
        chk("R8", {31'd0, dec_irq}, 32'd0);
        cyc("R6", 0, 1, 2, 32'h0000_0005, 0, 0);                       // positive write
        cyc("R6", 0, 1, 2, 32'h8000_0000, 0, 0);                       // neg over pos -> irq
        chk("R6", {31'd0, dec_irq}, 32'd1);
        cyc("R8", 0, 0, 0, 0, 0, 1);
        cyc("R6", 0, 1, 2, 32'h9000_0000, 0, 0);                       // neg over neg -> none
        chk("R6", {31'd0, dec_irq}, 32'd0);
        cyc("R7", 0, 1, 2, 32'h0000_0000, 0, 0);
        cyc("R7", 1, 1, 2, 32'h8000_0001, 1, 0);                       // reload beats neg write
        chk("R7", {31'd0, dec_irq}, 32'd0);
        cyc("R7", 0, 1, 2, 32'h0000_0000, 0, 0);
        cyc("R8", 1, 0, 0, 0, 0, 1);                                   // expiry with ack: set wins
        chk("R8", {31'd0, dec_irq}, 32'd1);
        cyc("R8", 0, 0, 0, 0, 0, 1);
        cyc("R11", 0, 1, 3, 32'hDEAD_BEEF, 0, 0);                      // null write
        legacy_mode = 1'b1;
        cyc("R10", 0, 1, 0, 32'hFFFF_FFFF, 0, 0);
        cyc("R10", 1, 0, 0, 0, 0, 0);
        legacy_mode = 1'b0;
        verify("R10");                                                 // unmasked view

        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r, d;
            logic [1:0]  s;
            r = $urandom;
            s = 2'($urandom % 4);
            d = $urandom;
            if (s == 2'd2 && r[20]) d = $urandom % 4;
            if (s == 2'd0 && r[21]) d = 32'hFFFF_FFF0 | ($urandom % 16);
            if (r[7:0] == 8'h00) legacy_mode = ~legacy_mode;
            cyc("R9", r[8] | r[9], r[12:10] == 3'd0, s, d, r[17:13] == 5'd0, r[19:18] == 2'd0);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule